// File: doc/BRIEF.md
# UART receiver with watermark RTS

This block is the receive half of a serial port. It oversamples the RX line with the system clock, using a run-time divider that gives the number of clocks per bit. It finds the start bit, confirms it, and takes the data, parity and stop bits each at mid-bit. It then stores each character in a 480-entry receive queue. The frame format is chosen at run time: 5 to 8 data bits, one of five parity modes, and one, one-and-a-half or two stop bits.

A consumer drains the queue through a valid/ready pair. An active-low ready-to-send output lets the remote transmitter keep going while fewer than 450 characters are waiting. It pauses the transmitter once the queue holds 450 or more. Three sticky flags report parity mismatches, low stop bits and characters lost to a full queue. A flush input empties the queue at once. A host uses the flush input when the channel is opened.

Top module: `uart_rx_flow`

## Requirements
- R1: After reset the output is not valid, rts_n_o is 0 (send allowed), and par_err_o, frm_err_o and ovr_err_o are 0.
- R2: A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then the stop bits. width_i selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. The character is delivered in the low bits of out_data_o, and the unused upper bits are 0.
- R3: A low level on RX that has returned high by the middle of the start bit is rejected and produces no character.
- R4: parity_i codes are 0 for none, 1 for even, 2 for odd, 3 for mark and 4 for space. Codes 5 to 7 act as none. Under even parity the data and parity bits together hold an even number of ones, and under odd parity an odd number. Mark expects a 1 and space expects a 0. A mismatch sets par_err_o, and the character is still stored.
- R5: stop_i codes are 0 for one stop bit, 1 for one and a half, and 2 or 3 for two. One and a half applies only with 5 data bits, and with other widths code 1 acts as two. Every stop bit is sampled, and the half bit is sampled at its middle. Any low stop sample sets frm_err_o, and the character is still stored.
- R6: The queue holds up to 480 characters and returns them in arrival order. out_valid_o is high while the queue is not empty. Data is held stable until out_ready_i accepts it.
- R7: rts_n_o is 0 while fewer than 450 characters are queued and 1 at 450 or more. It returns to 0 in the cycle after occupancy drops back below 450.
- R8: A character that completes while 480 characters are queued is discarded, ovr_err_o is set, and the queued contents are unchanged.
- R9: A flush pulse empties the queue in the following cycle, which brings out_valid_o to 0 and rts_n_o to 0. It leaves the three error flags unchanged.
- R10: par_err_o, frm_err_o and ovr_err_o stay set until reset, whatever later traffic arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| div_i | input | DIV_W | Clocks per bit period (at least 4) |
| width_i | input | 2 | Data-bit count code (5 to 8) |
| parity_i | input | 3 | Parity mode code |
| stop_i | input | 2 | Stop length code |
| flush_i | input | 1 | Empties the receive queue |
| out_valid_o | output | 1 | Queue head holds a character |
| out_data_o | output | 8 | Character at queue head |
| out_ready_i | input | 1 | Consumer accepts the head character |
| rts_n_o | output | 1 | Ready-to-send, low while below the watermark |
| par_err_o | output | 1 | Sticky parity mismatch flag |
| frm_err_o | output | 1 | Sticky low stop bit flag |
| ovr_err_o | output | 1 | Sticky dropped-character flag |

## Verification
RX passes through a two-stage synchronizer, so each mid-bit sample sees the line about two clocks after the bit's middle. A received character reaches out_valid_o two edges after the sample of its final stop bit. The bench gives every frame two idle bit times before it samples, so each result is settled when read. Pops, flushes, watermark crossings and overruns change the ports one edge after their cause. The bench drives every stimulus at a falling edge and reads the ports at the next falling edge or later.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bad;
        logic              frm_bad;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       width_i,
    input  logic [2:0]       parity_i,
    input  logic [1:0]       stop_i,
    output logic             char_valid_o,
    output rx_char_t         char_o
);

    typedef struct packed {
        logic              sync1;
        logic              sync2;
        rx_state_e         st;
        logic [DIV_W-1:0]  cnt;
        logic [2:0]        bit_idx;
        logic [CHAR_W-1:0] shreg;
        logic              par_bad;
        logic              frm_bad;
        logic              second_stop;
        logic              valid;
    } fr_regs_t;

    fr_regs_t q, d;

    logic [2:0]       last_bit;
    logic             has_par;
    logic             exp_par;
    logic             two_stops;
    logic             half_stop;
    logic [DIV_W-1:0] cnt_bit;
    logic [DIV_W-1:0] cnt_half;
    logic [DIV_W-1:0] cnt_3q;

    always_comb begin
        last_bit  = {1'b0, width_i} + 3'd4;
        has_par   = (parity_i >= PAR_EVEN) && (parity_i <= PAR_SPACE);
        half_stop = (stop_i == 2'd1) && (width_i == 2'd0);
        two_stops = (stop_i != 2'd0);
        cnt_bit   = div_i - DIV_W'(1);
        cnt_half  = (div_i >> 1) - DIV_W'(1);
        cnt_3q    = div_i - (div_i >> 2) - DIV_W'(1);
        case (parity_i)
            PAR_EVEN:  exp_par = ^q.shreg;
            PAR_ODD:   exp_par = ~^q.shreg;
            PAR_MARK:  exp_par = 1'b1;
            default:   exp_par = 1'b0;
        endcase
    end

    always_comb begin
        d       = q;
        d.sync1 = rx_i;
        d.sync2 = q.sync1;
        d.valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (!q.sync2) begin
                    d.st  = ST_START;
                    d.cnt = cnt_half;
                end
            end
            ST_START: begin
                if (q.cnt == '0) begin
                    if (!q.sync2) begin
                        d.st          = ST_DATA;
                        d.cnt         = cnt_bit;
                        d.bit_idx     = '0;
                        d.shreg       = '0;
                        d.par_bad     = 1'b0;
                        d.frm_bad     = 1'b0;
                        d.second_stop = 1'b0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            ST_DATA: begin
                if (q.cnt == '0) begin
                    d.shreg[q.bit_idx] = q.sync2;
                    d.cnt              = cnt_bit;
                    if (q.bit_idx == last_bit) begin
                        d.st = has_par ? ST_PAR : ST_STOP;
                    end else begin
                        d.bit_idx = q.bit_idx + 3'd1;
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            ST_PAR: begin
                if (q.cnt == '0) begin
                    d.par_bad = (q.sync2 != exp_par);
                    d.st      = ST_STOP;
                    d.cnt     = cnt_bit;
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            ST_STOP: begin
                if (q.cnt == '0) begin
                    d.frm_bad = q.frm_bad | ~q.sync2;
                    if (!q.second_stop && two_stops) begin
                        d.second_stop = 1'b1;
                        d.cnt         = half_stop ? cnt_3q : cnt_bit;
                    end else begin
                        d.valid = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q             <= '0;
            q.sync1       <= 1'b1;
            q.sync2       <= 1'b1;
            q.st          <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign char_valid_o = q.valid;
    assign char_o       = '{data: q.shreg, par_bad: q.par_bad, frm_bad: q.frm_bad};

    // R2: each completed frame yields exactly one single-cycle strobe
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R3: a start that reads high at mid-bit returns to idle
    a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && q.cnt == '0 && q.sync2) |=> (q.st == ST_IDLE && !q.valid));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH     = 480,
    parameter int WATERMARK = 450
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CHAR_W-1:0] wr_data_i,
    input  logic              rd_ready_i,
    input  logic              flush_i,
    output logic              rd_valid_o,
    output logic [CHAR_W-1:0] rd_data_o,
    output logic              drop_o,
    output logic              above_wm_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WM_CNT   = CNT_W'(WATERMARK);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             drop;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [CHAR_W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        do_rd = (q.count != '0) && rd_ready_i && !flush_i;
        do_wr = wr_i && (q.count != FULL_CNT) && !flush_i;
        d     = q;
        d.drop = wr_i && (q.count == FULL_CNT) && !flush_i;
        if (flush_i) begin
            d.wr_ptr = '0;
            d.rd_ptr = '0;
            d.count  = '0;
        end else begin
            if (do_wr) begin
                d.wr_ptr = (q.wr_ptr == LAST_PTR) ? '0 : q.wr_ptr + PTR_W'(1);
            end
            if (do_rd) begin
                d.rd_ptr = (q.rd_ptr == LAST_PTR) ? '0 : q.rd_ptr + PTR_W'(1);
            end
            d.count = q.count + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[q.wr_ptr] <= wr_data_i;
        end
    end

    assign rd_valid_o = (q.count != '0);
    assign rd_data_o  = mem[q.rd_ptr];
    assign drop_o     = q.drop;
    assign above_wm_o = (q.count >= WM_CNT);

    // R6: occupancy never exceeds capacity
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= FULL_CNT);

    // R6: an unaccepted head character stays put
    a_r6_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i && !flush_i) |=> (rd_valid_o && $stable(rd_data_o)));

    // R7: a write that reaches the watermark raises the pause request
    a_r7_wm_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (q.count == WM_CNT - CNT_W'(1) && do_wr && !do_rd) |=> above_wm_o);

    // R9: flush leaves the queue empty
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !rd_valid_o);

endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
    import uart_rx_pkg::*;
#(
    parameter int DEPTH     = 480,
    parameter int WATERMARK = 450,
    parameter int DIV_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [1:0]        width_i,
    input  logic [2:0]        parity_i,
    input  logic [1:0]        stop_i,
    input  logic              flush_i,
    output logic              out_valid_o,
    output logic [CHAR_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              rts_n_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              ovr_err_o
);

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic ovr_err;
    } flag_regs_t;

    flag_regs_t q, d;
    logic       ch_valid;
    rx_char_t   ch;
    logic       drop;
    logic       above_wm;

    uart_rx_frame #(.DIV_W(DIV_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx_i),
        .div_i        (div_i),
        .width_i      (width_i),
        .parity_i     (parity_i),
        .stop_i       (stop_i),
        .char_valid_o (ch_valid),
        .char_o       (ch)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .WATERMARK(WATERMARK)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ch_valid),
        .wr_data_i  (ch.data),
        .rd_ready_i (out_ready_i),
        .flush_i    (flush_i),
        .rd_valid_o (out_valid_o),
        .rd_data_o  (out_data_o),
        .drop_o     (drop),
        .above_wm_o (above_wm)
    );

    always_comb begin
        d         = q;
        d.par_err = q.par_err | (ch_valid & ch.par_bad);
        d.frm_err = q.frm_err | (ch_valid & ch.frm_bad);
        d.ovr_err = q.ovr_err | drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rts_n_o   = above_wm;
    assign par_err_o = q.par_err;
    assign frm_err_o = q.frm_err;
    assign ovr_err_o = q.ovr_err;

    // R4: a parity mismatch on a completed frame raises the flag
    a_r4_par_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && ch.par_bad) |=> par_err_o);

    // R8: a dropped character raises the overrun flag
    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_err_o);

    // R10: flags never clear without reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_o || frm_err_o || ovr_err_o) |=>
            (par_err_o >= $past(par_err_o) && frm_err_o >= $past(frm_err_o)
             && ovr_err_o >= $past(ovr_err_o)));

endmodule

// File: tb/uart_rx_flow_tb.sv
`timescale 1ns/1ps
module uart_rx_flow_tb;

    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic [15:0] div = 16'(DIV);
    logic [1:0]  width = 2'd3;
    logic [2:0]  parity = 3'd0;
    logic [1:0]  stop = 2'd0;
    logic        flush = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        rts_n, par_err, frm_err, ovr_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_rx_flow u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .div_i(div), .width_i(width),
        .parity_i(parity), .stop_i(stop), .flush_i(flush),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
        .rts_n_o(rts_n), .par_err_o(par_err), .frm_err_o(frm_err), .ovr_err_o(ovr_err)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(logic v, int clocks);
        rx = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx    = 1'b1;
        flush = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(int val, int nb, int par, int stp,
                        bit bad_par, bit bad_s1, bit bad_s2);
        int  ones;
        logic p;
        width  = 2'(nb - 5);
        parity = 3'(par);
        stop   = 2'(stp);
        hold(1'b0, DIV);
        for (int i = 0; i < nb; i++) hold(val[i], DIV);
        if (par >= 1 && par <= 4) begin
            ones = $countones(val & ((1 << nb) - 1));
            case (par)
                1: p = ones[0];
                2: p = ~ones[0];
                3: p = 1'b1;
                default: p = 1'b0;
            endcase
            if (bad_par) p = ~p;
            hold(p, DIV);
        end
        hold(!bad_s1, DIV);
        if (stp == 1 && nb == 5) hold(!bad_s2, DIV / 2);
        else if (stp != 0)       hold(!bad_s2, DIV);
        hold(1'b1, 2 * DIV);
    endtask

    task automatic pop();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int v;
        do_reset();
        // R1 reset state
        chk("R1 valid", out_valid, 0);
        chk("R1 rts_n", rts_n, 0);
        chk("R1 flags", {par_err, frm_err, ovr_err}, 0);

        // R2 R4 R5 sweep of formats with clean frames
        for (int w = 5; w <= 8; w++)
            for (int p = 0; p <= 4; p++)
                for (int s = 0; s <= 2; s++)
                    for (int k = 0; k < 4; k++) begin
                        v = (k == 0) ? 0 : (k == 1) ? 255 : ((k * 91 + w * 17 + p * 29 + s * 7) & 255);
                        send(v, w, p, s, 0, 0, 0);
                        chk("R2 valid", out_valid, 1);
                        chk("R2 data", out_data, v & ((1 << w) - 1));
                        pop();
                        chk("R6 empty after pop", out_valid, 0);
                    end
        chk("R4 no false parity", par_err, 0);
        chk("R5 no false framing", frm_err, 0);

        // R3 short glitch rejected
        hold(1'b0, 2);
        hold(1'b1, 4 * DIV);
        chk("R3 glitch ignored", out_valid, 0);

        // R4 parity errors, character kept; R10 sticky
        for (int p = 1; p <= 4; p++) begin
            do_reset();
            send(8'h6B, 8, p, 0, 1, 0, 0);
            chk("R4 par_err set", par_err, 1);
            chk("R4 char kept", out_data, 8'h6B);
            chk("R4 frm clear", frm_err, 0);
            pop();
            send(8'h12, 8, p, 0, 0, 0, 0);
            chk("R10 par sticky", par_err, 1);
            chk("R4 good after bad", out_data, 8'h12);
        end

        // R5 framing errors on each stop position
        do_reset();
        send(8'hC3, 8, 0, 0, 0, 1, 0);
        chk("R5 one stop low", frm_err, 1);
        chk("R5 char kept", out_data, 8'hC3);
        pop();
        chk("R5 single char", out_valid, 0);
        chk("R5 parity untouched", par_err, 0);
        do_reset();
        send(5'h15, 5, 0, 1, 0, 0, 1);
        chk("R5 half stop low", frm_err, 1);
        chk("R5 half stop char", out_data, 8'h15);
        do_reset();
        send(8'h5A, 8, 0, 1, 0, 0, 1);
        chk("R5 code1 width8 acts as two", frm_err, 1);
        do_reset();
        send(7'h33, 7, 2, 2, 0, 0, 1);
        chk("R5 second stop low", frm_err, 1);
        chk("R5 two stop char", out_data, 8'h33);
        send(7'h01, 7, 2, 2, 0, 0, 0);
        chk("R10 frm sticky", frm_err, 1);

        // R6 R7 R8 fill past capacity
        do_reset();
        for (int i = 0; i < 481; i++) begin
            send(i & 255, 8, 0, 0, 0, 0, 0);
            if (i == 448) chk("R7 rts low at 449", rts_n, 0);
            if (i == 449) chk("R7 rts high at 450", rts_n, 1);
            if (i == 479) chk("R8 no overrun at full", ovr_err, 0);
        end
        chk("R8 overrun set", ovr_err, 1);
        for (int i = 0; i < 480; i++) begin
            chk("R6 order", out_data, i & 255);
            pop();
            if (i == 29) chk("R7 rts high at 450 left", rts_n, 1);
            if (i == 30) chk("R7 rts low at 449 left", rts_n, 0);
        end
        chk("R8 dropped char absent", out_valid, 0);

        // R9 flush
        send(8'hA1, 8, 0, 0, 0, 0, 0);
        send(8'hA2, 8, 0, 0, 0, 0, 0);
        send(8'hA3, 8, 0, 0, 0, 0, 0);
        chk("R9 loaded", out_valid, 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R9 empty", out_valid, 0);
        chk("R9 rts low", rts_n, 0);
        chk("R9 flags kept", ovr_err, 1);
        send(8'h3C, 8, 0, 0, 0, 0, 0);
        chk("R9 new data after flush", out_data, 8'h3C);
        pop();
        chk("R9 only new char", out_valid, 0);
        chk("R10 ovr sticky", ovr_err, 1);

        finish_run();
    end

endmodule